// File: doc/BRIEF.md
# Power-Management Event Status and Interrupt Router

This block holds a group of power-management event flags next to their interrupt masks and one routing register. Each bit of the event input vector is a one-cycle pulse from an external event detector. A pulse sets the matching status flag, and the flag stays set until software clears it. The group interrupt is the OR of every status flag whose mask bit is set. A routing field sends this level interrupt to one of three destinations: a dedicated interrupt pin, a combined wake/system-control pin, or one slot of a serial interrupt vector.

The block has two power-on resets. The main-supply reset clears only the status flags. The battery-domain reset returns every register to its default value. The masks and the routing setting therefore survive a loss of main power. Some event positions, chosen by a parameter, have no mask bit. Software can only poll those flags, and they never raise the interrupt.

Software uses a simple single-cycle register bus. Writes take effect at the next clock edge. The read data is a combinational decode of the address.

Top module: `pm_event_block`

## Requirements
- R1: A status flag becomes set only in the cycle after its event input was high. No register write ever sets a status flag.
- R2: Writing a 1 to a bit at address 0 clears that status flag. Writing a 0 leaves the flag as it was.
- R3: If an event pulse and a clearing write hit the same status bit in the same cycle, the flag ends up set.
- R4: The main-supply reset (active low) clears all status flags. It leaves the mask and routing registers unchanged.
- R5: The battery-domain reset (active low) clears the status flags and the masks, and sets the routing register to 0.
- R6: The group interrupt is high exactly when some status flag and its mask bit are both set. A flag that was set while masked raises the interrupt once the mask is set. The interrupt stays high until every such pair is removed.
- R7: Bits named in parameter NOEN (default bit 7) have no mask. At address 1 those bits read 0 and ignore writes, and their status flags never raise the interrupt.
- R8: Address 0 reads the status flags, 1 the masks and 2 the routing register. Address 3 reads 0, and writes to it have no effect.
- R9: Routing register bits [1:0] choose the destination. 0 drives irq_pin, 1 drives wake_pin, 2 drives ser_irq bit [5:2], and 3 drives nothing. At most one destination is ever active.
- R10: Routing register bits [7:6] are reserved. They read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_main_n | input | 1 | Main-supply power-on reset, active low, asynchronous |
| por_batt_n | input | 1 | Battery-domain power-on reset, active low, asynchronous |
| evt | input | 8 | Hardware event pulses, one per status flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq_pin | output | 1 | Routed interrupt on the dedicated pin |
| wake_pin | output | 1 | Routed interrupt on the wake/system-control pin |
| ser_irq | output | 16 | Routed interrupt, one-hot by serial slot |

## Verification
An event pulse and a software clear can hit the same status flag in one cycle. The bench provokes this by driving an event bit together with a write of 1 to that bit. It then confirms, through the status read, that the flag stays set and the interrupt stays high. A behavioural model in the bench follows the set-over-clear rule and is compared with every output on every cycle. A second overlap is a main-supply reset that arrives while masks and routing are programmed. The bench judges that case by reading the mask and routing registers back afterwards and checking that the interrupt comes back once a new event occurs.

// File: rtl/pm_event_block.sv
module pm_event_block #(
  parameter int N_EVT  = 8,
  parameter int SLOT_W = 4,
  parameter logic [N_EVT-1:0] NOEN = 8'h80
) (
  input  logic                   clk,
  input  logic                   por_main_n,
  input  logic                   por_batt_n,
  input  logic [N_EVT-1:0]       evt,
  input  logic                   wr_en,
  input  logic [1:0]             addr,
  input  logic [N_EVT-1:0]       wdata,
  output logic [N_EVT-1:0]       rdata,
  output logic                   irq_pin,
  output logic                   wake_pin,
  output logic [(1<<SLOT_W)-1:0] ser_irq
);
  localparam int CTL_W = 2 + SLOT_W;
  localparam logic [1:0] RT_PIN = 2'd0, RT_WAKE = 2'd1, RT_SER = 2'd2;

  logic [N_EVT-1:0] stat, en;
  logic [CTL_W-1:0] ctl;
  logic             stat_rst_n, grp;

  assign stat_rst_n = por_main_n & por_batt_n;

  always_ff @(posedge clk or negedge stat_rst_n)
    if (!stat_rst_n) stat <= '0;
    else if (wr_en && addr == 2'd0) stat <= (stat & ~wdata) | evt;
    else stat <= stat | evt;

  always_ff @(posedge clk or negedge por_batt_n)
    if (!por_batt_n) begin
      en  <= '0;
      ctl <= '0;
    end else if (wr_en) begin
      if (addr == 2'd1) en  <= wdata & ~NOEN;
      if (addr == 2'd2) ctl <= wdata[CTL_W-1:0];
    end

  always_comb
    case (addr)
      2'd0:    rdata = stat;
      2'd1:    rdata = en;
      2'd2:    rdata = N_EVT'(ctl);
      default: rdata = '0;
    endcase

  assign grp      = |(stat & en);
  assign irq_pin  = grp && ctl[1:0] == RT_PIN;
  assign wake_pin = grp && ctl[1:0] == RT_WAKE;
  assign ser_irq  = (grp && ctl[1:0] == RT_SER) ? ((1<<SLOT_W)'(1) << ctl[CTL_W-1:2]) : '0;
endmodule

module pm_event_chk #(
  parameter int N_EVT  = 8,
  parameter int SLOT_W = 4,
  parameter logic [N_EVT-1:0] NOEN = 8'h80
) (
  input logic                   clk,
  input logic                   por_main_n,
  input logic                   por_batt_n,
  input logic [N_EVT-1:0]       evt,
  input logic                   wr_en,
  input logic [1:0]             addr,
  input logic [N_EVT-1:0]       wdata,
  input logic [N_EVT-1:0]       stat,
  input logic [N_EVT-1:0]       en,
  input logic [N_EVT-1:0]       rdata,
  input logic                   irq_pin,
  input logic                   wake_pin,
  input logic [(1<<SLOT_W)-1:0] ser_irq
);
  logic rst_ok;
  assign rst_ok = por_main_n & por_batt_n;

  AST_SET_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> ((stat & ~$past(stat) & ~$past(evt)) == '0)); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok && wr_en && addr == 2'd0) |-> ((stat & $past(wdata) & ~$past(evt)) == '0)); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> ((~stat & $past(evt)) == '0)); // R3
  AST_MASK_SURVIVES: assert property (@(posedge clk) disable iff (!por_batt_n)
    ($past(por_batt_n) && !$past(wr_en && addr == 2'd1)) |-> (en == $past(en))); // R4
  AST_GATED_IRQ: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_pin || wake_pin || (|ser_irq)) |-> (|(stat & en))); // R6
  AST_NOEN_READS_ZERO: assert property (@(posedge clk) disable iff (!por_batt_n)
    (addr == 2'd1) |-> ((rdata & NOEN) == '0)); // R7
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!por_batt_n)
    (addr == 2'd3) |-> (rdata == '0)); // R8
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({irq_pin, wake_pin, |ser_irq}) && $onehot0(ser_irq)); // R9
endmodule

bind pm_event_block pm_event_chk #(.N_EVT(N_EVT), .SLOT_W(SLOT_W), .NOEN(NOEN)) u_chk (
  .clk(clk), .por_main_n(por_main_n), .por_batt_n(por_batt_n), .evt(evt),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .stat(stat), .en(en), .rdata(rdata),
  .irq_pin(irq_pin), .wake_pin(wake_pin), .ser_irq(ser_irq)
);

// File: tb/sim_pm_event_block.sv
`timescale 1ns/1ps
module sim_pm_event_block;
  logic        clk = 0, rm = 0, rb = 0, wr = 0;
  logic [7:0]  evt = 0, wd = 0;
  logic [1:0]  a = 0;
  logic [7:0]  rdata;
  logic        irq_pin, wake_pin;
  logic [15:0] ser_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  pm_event_block u0 (.clk(clk), .por_main_n(rm), .por_batt_n(rb), .evt(evt), .wr_en(wr),
    .addr(a), .wdata(wd), .rdata(rdata), .irq_pin(irq_pin), .wake_pin(wake_pin), .ser_irq(ser_irq));

  always #10 clk = ~clk;

  // behavioural reference
  logic [7:0] m_st = 0, m_en = 0, m_ctl = 0;
  always @(posedge clk) begin
    if (!rb) begin m_st = 0; m_en = 0; m_ctl = 0; end
    else begin
      if (wr && a == 1) m_en = wd & 8'h7F;
      if (wr && a == 2) m_ctl = wd & 8'h3F;
      if (!rm) m_st = 0;
      else begin
        if (wr && a == 0) m_st = m_st & ~wd;
        m_st = m_st | evt;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [7:0] st, en, ctl, erd;
    logic grp;
    st = m_st; en = m_en; ctl = m_ctl;
    if (!rb) begin st = 0; en = 0; ctl = 0; end
    if (!rm) st = 0;
    grp = |(st & en);
    erd = (a == 0) ? st : (a == 1) ? en : (a == 2) ? ctl : 8'h00;
    chk("R8 rdata", rdata, erd);
    chk("R6 irq_pin", irq_pin, grp && ctl[1:0] == 0);
    chk("R9 wake_pin", wake_pin, grp && ctl[1:0] == 1);
    chk("R9 ser_irq", ser_irq, (grp && ctl[1:0] == 2) ? (16'h1 << ctl[5:2]) : 16'h0);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic wreg(input logic [1:0] ad, input logic [7:0] d, input logic [7:0] e = 0);
    a = ad; wd = d; wr = 1; evt = e; step(); wr = 0; evt = 0;
  endtask
  task automatic pulse(input logic [7:0] e);
    evt = e; step(); evt = 0;
  endtask
  task automatic rd(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    a = ad; @(negedge clk); #1; chk(tag, rdata, exp); step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2); rb = 1; rm = 1; step();
    rd(0, 8'h00, "R5 status default");
    rd(1, 8'h00, "R5 mask default");
    rd(2, 8'h00, "R5 route default");
    pulse(8'h05);
    rd(0, 8'h05, "R6 masked event still latched");
    @(negedge clk); #1; chk("R6 masked no irq", irq_pin, 0); step();
    wreg(1, 8'h04);
    @(negedge clk); #1; chk("R6 irq on late enable", irq_pin, 1); step();
    wreg(0, 8'h00);
    rd(0, 8'h05, "R2 write zero no effect");
    wreg(0, 8'h04);
    @(negedge clk); #1; chk("R6 irq drops on clear", irq_pin, 0); step();
    rd(0, 8'h01, "R2 w1c one bit");
    wreg(0, 8'hFF);
    rd(0, 8'h00, "R1 writes never set");
    wreg(1, 8'h0C);
    wreg(0, 8'h08, 8'h08);
    rd(0, 8'h08, "R3 event beats clear");
    @(negedge clk); #1; chk("R3 irq held", irq_pin, 1); step();
    wreg(0, 8'hFF);
    wreg(1, 8'hFF);
    rd(1, 8'h7F, "R7 no mask bit");
    pulse(8'h80);
    rd(0, 8'h80, "R7 flag pollable");
    @(negedge clk); #1; chk("R7 never interrupts", irq_pin, 0); step();
    wreg(2, 8'hFF);
    rd(2, 8'h3F, "R10 reserved control bits");
    pulse(8'h02);
    @(negedge clk); #1; chk("R9 route none", {irq_pin, wake_pin, |ser_irq}, 0); step();
    wreg(2, 8'h01);
    @(negedge clk); #1; chk("R9 wake route", wake_pin, 1); step();
    wreg(2, 8'h2A);
    @(negedge clk); #1; chk("R9 serial slot 10", ser_irq, 16'h0400); step();
    wreg(3, 8'hFF);
    rd(3, 8'h00, "R8 hole reads zero");
    rd(2, 8'h2A, "R8 hole write ignored");
    rm = 0; step(2); rm = 1; step();
    rd(0, 8'h00, "R4 status cleared");
    rd(1, 8'h7F, "R4 mask kept");
    rd(2, 8'h2A, "R4 route kept");
    pulse(8'h10);
    @(negedge clk); #1; chk("R4 irq returns", ser_irq, 16'h0400); step();
    rb = 0; step(2); rb = 1; step();
    rd(0, 8'h00, "R5 status cleared");
    rd(1, 8'h00, "R5 mask cleared");
    rd(2, 8'h00, "R5 route cleared");
    step(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule